// File: doc/BRIEF.md
# UART Channel Enable/Disable Controller

This block sequences the start and stop of one serial channel's transmit and receive paths. Software issues one-cycle command strobes to enable or disable either direction, or to reset the receiver. From these strobes, the wake-up mode bit and live status from the FIFOs and shifters, the block drives the flags that tell the data path when it may run. The shifters and FIFOs sit outside this block.

Stopping the transmitter is graceful. The ready and empty flags drop at once and new FIFO writes are refused. Characters already queued or being shifted still go out, and only then does the transmitter fall idle. A fresh enable during that drain cancels the stop. Stopping the receiver takes effect at once: a character in flight is abandoned, but bytes already in the receive FIFO stay readable. Only a receiver reset flushes them. With wake-up mode set, the receiver keeps listening even while it is disabled.

Top module: `uart_chan_ctl`

## Requirements
- R1: After reset, every output is low: both directions are inactive and no pulse is issued.
- R2: One cycle after an enable-transmit strobe, `txf_wr_allow` is high. `tx_rdy` is then high whenever `txf_full` is low. `tx_emt` is then high whenever `txf_empty` and `txs_done` are both high.
- R3: One cycle after a disable-transmit strobe (with no enable in the same cycle), `tx_rdy` and `tx_emt` are low. `tx_active` stays high while the FIFO is not empty or the shifter has not finished.
- R4: A draining transmitter drops `tx_active` one cycle after a cycle in which `txf_empty` and `txs_done` are both high.
- R5: `txf_wr_allow` is high only in the enabled state. It is low both while idle and while draining.
- R6: An enable-transmit strobe during draining returns the transmitter to the enabled state, with `txf_wr_allow`, `tx_rdy` and `tx_emt` following R2.
- R7: One cycle after a disable-receive strobe, `rx_active` is low unless wake-up mode is set. If the receiver was running without wake-up mode and `rxs_busy` was high, `rx_drop` pulses high for one cycle.
- R8: A disable-receive strobe never raises `rx_flush`. A receiver-reset strobe disables the receiver and raises `rx_flush` for exactly the next cycle.
- R9: While `wakeup_mode` is high, `rx_active` is high regardless of the enable state.
- R10: An enable-receive strobe taken while `wakeup_mode` is low raises `rx_hunt` for HUNT_CYCLES cycles starting the next cycle. With `wakeup_mode` high, no hunt pulse is issued.
- R11: With the default DIS_WINS = 1, an enable and a disable strobe for the same direction in the same cycle act as a disable. A receiver reset overrides an enable-receive strobe in every configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en_cmd | input | 1 | Enable-transmit strobe |
| tx_dis_cmd | input | 1 | Disable-transmit strobe |
| rx_en_cmd | input | 1 | Enable-receive strobe |
| rx_dis_cmd | input | 1 | Disable-receive strobe |
| rx_reset_cmd | input | 1 | Receiver-reset strobe |
| wakeup_mode | input | 1 | Receiver keeps running while disabled |
| txf_empty | input | 1 | Transmit FIFO holds no character |
| txf_full | input | 1 | Transmit FIFO cannot take a character |
| txs_done | input | 1 | Transmit shifter finished its last stop bit |
| rxs_busy | input | 1 | Receive shifter is mid-character |
| tx_active | output | 1 | Transmitter may shift characters out |
| tx_rdy | output | 1 | Transmit-ready flag |
| tx_emt | output | 1 | Transmitter-empty flag |
| txf_wr_allow | output | 1 | Transmit FIFO writes are accepted |
| rx_active | output | 1 | Receiver is running |
| rx_hunt | output | 1 | Force receiver to search for a start bit |
| rx_flush | output | 1 | Discard unread receive FIFO contents |
| rx_drop | output | 1 | Abandon the partially received character |

## Verification
The assertions assume that the status inputs are consistent: `txf_full` and `txf_empty` are never high together, and a strobe lasts one cycle per command. The random stimulus draws the FIFO level as one of three exclusive states (empty, partly filled, full), so the two flags can never conflict. It keeps command strobes sparse, which lets the drain and enabled states persist long enough to be observed. Directed sequences before the random phase cover the cases that sparse stimulus rarely reaches: simultaneous enable and disable strobes, and re-enabling during a drain.

// File: rtl/uart_chan_ctl_pkg.sv
package uart_chan_ctl_pkg;
   typedef enum logic [1:0] {
      TX_IDLE   = 2'd0,
      TX_ACTIVE = 2'd1,
      TX_DRAIN  = 2'd2
   } tx_state_t;
endpackage

// File: rtl/uart_cmd_arb.sv
module uart_cmd_arb #(
   parameter int DIS_WINS = 1
) (
   input  logic on_req,
   input  logic off_req,
   output logic on_eff,
   output logic off_eff
);
   initial assert (DIS_WINS == 0 || DIS_WINS == 1)
      else $error("DIS_WINS must be 0 or 1");

   generate
      if (DIS_WINS == 1) begin : g_off_first
         assign on_eff  = on_req & ~off_req;
         assign off_eff = off_req;
      end else begin : g_on_first
         assign on_eff  = on_req;
         assign off_eff = off_req & ~on_req;
      end
   endgenerate
endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
   import uart_chan_ctl_pkg::*;
#(
   parameter int DIS_WINS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_cmd,
   input  logic dis_cmd,
   input  logic fifo_empty,
   input  logic fifo_full,
   input  logic shift_done,
   output logic active,
   output logic rdy,
   output logic emt,
   output logic wr_allow
);
   tx_state_t state_q, state_d;
   logic      en_w, dis_w;
   logic      drained;

   uart_cmd_arb #(.DIS_WINS(DIS_WINS)) u_arb (
      .on_req (en_cmd),
      .off_req(dis_cmd),
      .on_eff (en_w),
      .off_eff(dis_w)
   );

   assign drained = fifo_empty & shift_done;

   always_comb begin
      state_d = state_q;
      if (en_w)
         state_d = TX_ACTIVE;
      else if (dis_w && state_q == TX_ACTIVE)
         state_d = TX_DRAIN;
      else if (state_q == TX_DRAIN && drained)
         state_d = TX_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= TX_IDLE;
      else        state_q <= state_d;
   end

   assign active   = (state_q != TX_IDLE);
   assign wr_allow = (state_q == TX_ACTIVE);
   assign rdy      = wr_allow & ~fifo_full;
   assign emt      = wr_allow & drained;

   AST_EN_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      en_w |=> wr_allow); // R2
   AST_DIS_DROPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_cmd && !en_cmd) |=> (!rdy && !emt)); // R3
   AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TX_DRAIN && !drained && !en_w) |=> active); // R3
   AST_DRAIN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TX_DRAIN && drained && !en_w) |=> !active); // R4
   AST_REENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TX_DRAIN && en_w) |=> (state_q == TX_ACTIVE)); // R6
endmodule

// File: rtl/uart_rx_seq.sv
module uart_rx_seq #(
   parameter int DIS_WINS    = 1,
   parameter int HUNT_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_cmd,
   input  logic dis_cmd,
   input  logic reset_cmd,
   input  logic wakeup,
   input  logic shift_busy,
   output logic active,
   output logic hunt,
   output logic flush,
   output logic drop
);
   localparam int HW = $clog2(HUNT_CYCLES + 1);

   initial assert (HUNT_CYCLES >= 1)
      else $error("HUNT_CYCLES must be at least 1");

   logic          en_q;
   logic          en_w, dis_w;
   logic          start, stop;
   logic [HW-1:0] hunt_cnt;

   uart_cmd_arb #(.DIS_WINS(DIS_WINS)) u_arb (
      .on_req (en_cmd),
      .off_req(dis_cmd),
      .on_eff (en_w),
      .off_eff(dis_w)
   );

   assign start = en_w & ~reset_cmd;
   assign stop  = dis_w | reset_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         hunt_cnt <= '0;
         flush    <= 1'b0;
         drop     <= 1'b0;
      end else begin
         if (start)     en_q <= 1'b1;
         else if (stop) en_q <= 1'b0;
         if (start && !wakeup)  hunt_cnt <= HW'(HUNT_CYCLES);
         else if (hunt_cnt != '0) hunt_cnt <= hunt_cnt - 1'b1;
         flush <= reset_cmd;
         drop  <= stop & en_q & ~wakeup & shift_busy;
      end
   end

   assign active = en_q | wakeup;
   assign hunt   = (hunt_cnt != '0);

   AST_RX_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !start) |=> !en_q); // R7
   AST_WAKE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      wakeup |-> active); // R9
   AST_FLUSH_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      reset_cmd |=> flush); // R8
   AST_NO_FLUSH_ON_DIS: assert property (@(posedge clk) disable iff (!rst_n)
      (!reset_cmd) |=> !flush); // R8
   AST_HUNT_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !wakeup) |=> hunt); // R10
   AST_RESET_BEATS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      reset_cmd |=> !en_q); // R11
endmodule

// File: rtl/uart_chan_ctl.sv
module uart_chan_ctl #(
   parameter int DIS_WINS    = 1,
   parameter int HUNT_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en_cmd,
   input  logic tx_dis_cmd,
   input  logic rx_en_cmd,
   input  logic rx_dis_cmd,
   input  logic rx_reset_cmd,
   input  logic wakeup_mode,
   input  logic txf_empty,
   input  logic txf_full,
   input  logic txs_done,
   input  logic rxs_busy,
   output logic tx_active,
   output logic tx_rdy,
   output logic tx_emt,
   output logic txf_wr_allow,
   output logic rx_active,
   output logic rx_hunt,
   output logic rx_flush,
   output logic rx_drop
);
   uart_tx_seq #(.DIS_WINS(DIS_WINS)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_cmd    (tx_en_cmd),
      .dis_cmd   (tx_dis_cmd),
      .fifo_empty(txf_empty),
      .fifo_full (txf_full),
      .shift_done(txs_done),
      .active    (tx_active),
      .rdy       (tx_rdy),
      .emt       (tx_emt),
      .wr_allow  (txf_wr_allow)
   );

   uart_rx_seq #(.DIS_WINS(DIS_WINS), .HUNT_CYCLES(HUNT_CYCLES)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_cmd    (rx_en_cmd),
      .dis_cmd   (rx_dis_cmd),
      .reset_cmd (rx_reset_cmd),
      .wakeup    (wakeup_mode),
      .shift_busy(rxs_busy),
      .active    (rx_active),
      .hunt      (rx_hunt),
      .flush     (rx_flush),
      .drop      (rx_drop)
   );

   AST_RDY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_rdy || tx_emt) |-> (txf_wr_allow && tx_active)); // R5
   AST_WRITE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      txf_wr_allow |-> tx_active); // R5
endmodule

// File: tb/uart_chan_ctl_test.sv
`timescale 1ns/1ps
module uart_chan_ctl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en_cmd = 0, tx_dis_cmd = 0, rx_en_cmd = 0, rx_dis_cmd = 0;
   logic rx_reset_cmd = 0, wakeup_mode = 0;
   logic txf_empty = 1, txf_full = 0, txs_done = 1, rxs_busy = 0;
   logic tx_active, tx_rdy, tx_emt, txf_wr_allow;
   logic rx_active, rx_hunt, rx_flush, rx_drop;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   int  m_tx = 0;
   bit  m_rx_en = 0, m_hunt = 0, m_flush = 0, m_drop = 0;

   always #2 clk = ~clk;

   uart_chan_ctl uut (
      .clk(clk), .rst_n(rst_n),
      .tx_en_cmd(tx_en_cmd), .tx_dis_cmd(tx_dis_cmd),
      .rx_en_cmd(rx_en_cmd), .rx_dis_cmd(rx_dis_cmd),
      .rx_reset_cmd(rx_reset_cmd), .wakeup_mode(wakeup_mode),
      .txf_empty(txf_empty), .txf_full(txf_full),
      .txs_done(txs_done), .rxs_busy(rxs_busy),
      .tx_active(tx_active), .tx_rdy(tx_rdy), .tx_emt(tx_emt),
      .txf_wr_allow(txf_wr_allow), .rx_active(rx_active),
      .rx_hunt(rx_hunt), .rx_flush(rx_flush), .rx_drop(rx_drop)
   );

   task automatic chk(input string tag, input string what, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
      end
   endtask

   function automatic bit exp_tx_next(input int s, output int nxt);
      bit en_w = tx_en_cmd && !tx_dis_cmd;
      nxt = s;
      if (en_w) nxt = 1;
      else if (tx_dis_cmd && s == 1) nxt = 2;
      else if (s == 2 && txf_empty && txs_done) nxt = 0;
      return en_w;
   endfunction

   task automatic model_step();
      int nxt;
      bit start, stop, unused;
      unused = exp_tx_next(m_tx, nxt);
      m_tx = nxt;
      start = rx_en_cmd && !rx_dis_cmd && !rx_reset_cmd;
      stop  = rx_dis_cmd || rx_reset_cmd;
      m_drop  = stop && m_rx_en && !wakeup_mode && rxs_busy;
      m_hunt  = start && !wakeup_mode;
      m_flush = rx_reset_cmd;
      if (start) m_rx_en = 1;
      else if (stop) m_rx_en = 0;
   endtask

   task automatic check_all(input string tag);
      chk(tag, "R3 R4 R6 tx_active", tx_active, m_tx != 0);
      chk(tag, "R2 R3 tx_rdy", tx_rdy, m_tx == 1 && !txf_full);
      chk(tag, "R2 R3 tx_emt", tx_emt, m_tx == 1 && txf_empty && txs_done);
      chk(tag, "R5 txf_wr_allow", txf_wr_allow, m_tx == 1);
      chk(tag, "R7 R9 rx_active", rx_active, m_rx_en || wakeup_mode);
      chk(tag, "R10 rx_hunt", rx_hunt, m_hunt);
      chk(tag, "R8 rx_flush", rx_flush, m_flush);
      chk(tag, "R7 rx_drop", rx_drop, m_drop);
   endtask

   task automatic cycle(input string tag);
      #1 check_all(tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   task automatic idle_cmds();
      tx_en_cmd = 0; tx_dis_cmd = 0; rx_en_cmd = 0; rx_dis_cmd = 0; rx_reset_cmd = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: everything low after reset
      cycle("R1");
      // R2: enable transmitter with idle fifo
      tx_en_cmd = 1; cycle("R2"); idle_cmds(); cycle("R2");
      // R3: disable with data queued, drain persists
      txf_empty = 0; tx_dis_cmd = 1; cycle("R3"); idle_cmds();
      cycle("R3"); cycle("R3");
      // R6: re-enable while draining
      tx_en_cmd = 1; cycle("R6"); idle_cmds(); cycle("R6");
      // R4: disable then drain completes
      tx_dis_cmd = 1; cycle("R4"); idle_cmds(); txf_empty = 1; txs_done = 0; cycle("R4");
      txs_done = 1; cycle("R4"); cycle("R4");
      // R11: simultaneous enable and disable
      tx_en_cmd = 1; tx_dis_cmd = 1; rx_en_cmd = 1; rx_dis_cmd = 1; cycle("R11");
      idle_cmds(); cycle("R11");
      rx_en_cmd = 1; rx_reset_cmd = 1; cycle("R11"); idle_cmds(); cycle("R11");
      // R10 then R7: enable receiver, disable mid-character
      rx_en_cmd = 1; cycle("R10"); idle_cmds(); rxs_busy = 1; cycle("R10");
      rx_dis_cmd = 1; cycle("R7"); idle_cmds(); cycle("R7");
      // R9: wake-up mode keeps receiver alive, no hunt on enable
      wakeup_mode = 1; cycle("R9"); rx_en_cmd = 1; cycle("R9");
      idle_cmds(); rx_dis_cmd = 1; cycle("R9"); idle_cmds(); cycle("R9");
      wakeup_mode = 0; rxs_busy = 0;
      // R8: receiver reset flushes
      rx_en_cmd = 1; cycle("R8"); idle_cmds(); rx_reset_cmd = 1; cycle("R8");
      idle_cmds(); cycle("R8"); cycle("R8");
      // random phase
      for (int i = 0; i < 4000; i++) begin
         int lvl;
         tx_en_cmd    = ($urandom % 16) == 0;
         tx_dis_cmd   = ($urandom % 16) == 0;
         rx_en_cmd    = ($urandom % 12) == 0;
         rx_dis_cmd   = ($urandom % 12) == 0;
         rx_reset_cmd = ($urandom % 40) == 0;
         if (($urandom % 50) == 0) wakeup_mode = ~wakeup_mode;
         lvl = $urandom % 3;
         txf_empty = (lvl == 0);
         txf_full  = (lvl == 2);
         txs_done  = ($urandom % 3) != 0;
         rxs_busy  = $urandom % 2;
         cycle("random");
      end
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule